// File: doc/BRIEF.md
# UART Interrupt Status and Clear Logic

This block keeps the raw interrupt status word of a UART and makes it visible on a small register bus. Five status bits are set by events from the datapath:

- a receive-timeout strobe;
- a transmit condition, which is either a fall of the transmit FIFO fill level to or below its trigger or the end of serialization, as selected by a mode input;
- a receive FIFO fill level that rises to its trigger;
- a change on either of two asynchronous modem-status inputs.

Once set, a bit stays set until it is cleared. Software clears a bit by writing 1 to its position through a write-1-to-clear address. The transmit and receive bits also clear themselves when FIFO traffic moves the fill level back across the trigger. When the FIFO is disabled, a single byte written or read clears them.

The datapath supplies fill levels, strobes and the mode settings. The mask comes in as a port. The block returns a raw view of the status, a masked view, and one combined interrupt line. The receive-timeout bit appears in the raw view only while its own mask bit is 1. There is no state machine: every bit is an independent set/clear flop, and the only sequencing is the modem-input synchronizer and the one-cycle history kept for each fill level.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset every status bit is 0, `irq` is 0 and reads at every address return 0. Status bit positions are: receive timeout 6, transmit 5, receive 4, first modem input (`dsr_in`) 3, second modem input (`dcd_in`) 2. Bits 1 and 0 always read 0.
- R2: Bus address 0 reads the raw status, address 1 reads the masked status, and address 2 is the clear register. A write to address 2 clears every status bit whose data bit is 1, one cycle later. Data bits that are 0 leave their status bits unchanged.
- R3: With `eot_mode`=0 and `fifo_en`=1, bit 5 sets in the cycle after `tx_level` goes from above the transmit trigger to at or below it. With `fifo_en`=0, bit 5 sets when `tx_level` goes from 1 or more to 0.
- R4: With `eot_mode`=1, bit 5 sets only on a `tx_done` strobe. Transmit level crossings do not set it in this mode.
- R5: With `fifo_en`=1, bit 5 clears when `tx_level` rises from at or below the trigger to above it. With `fifo_en`=0, a `tx_wr` strobe clears bit 5.
- R6: With `fifo_en`=1, bit 4 sets when `rx_level` rises from below the receive trigger to at or above it. With `fifo_en`=0, bit 4 sets when `rx_level` goes from 0 to 1 or more.
- R7: With `fifo_en`=1, bit 4 clears when `rx_level` falls from at or above the trigger to below it. With `fifo_en`=0, an `rx_rd` strobe clears bit 4.
- R8: An `rt_evt` strobe sets bit 6. Bit 6 reads as 1 in the raw view only while `mask[6]` is 1. The stored bit is kept while the mask is 0.
- R9: Any change on `dsr_in` or `dcd_in` passes through a two-flop synchronizer and sets bit 3 or bit 2 respectively. The bit reads as 1 after the third rising clock edge following the change.
- R10: A trigger code selects the trigger level for a FIFO of depth 16: 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14. Codes 5 to 7 give 8.
- R11: The masked view equals the raw view AND `mask`. `irq` is 1 exactly when the masked view is nonzero.
- R12: When a set event and a clear (write or automatic) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-byte holding mode |
| eot_mode | input | 1 | 1 makes the transmit bit mean end of serialization |
| tx_trig | input | 3 | Transmit trigger code |
| rx_trig | input | 3 | Receive trigger code |
| tx_level | input | 5 | Transmit FIFO fill level |
| rx_level | input | 5 | Receive FIFO fill level |
| tx_wr | input | 1 | Strobe: a byte was written for transmission |
| rx_rd | input | 1 | Strobe: a received byte was read |
| tx_done | input | 1 | Strobe: the last bit has left the serializer |
| rt_evt | input | 1 | Strobe: receive timeout |
| dsr_in | input | 1 | Asynchronous modem-status input, bit 3 |
| dcd_in | input | 1 | Asynchronous modem-status input, bit 2 |
| mask | input | 7 | Interrupt mask, same bit positions as the status |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | OR of all masked status bits |

## Verification
Each status bit is one flop, so any wrong stored value shows at the raw read address in the cycle after the event that produced it. It also reaches `irq` at once whenever that bit is unmasked. A fill-level history that is out of step with the real level shows up as a missing or spurious set or clear on the very next level change. It therefore never hides for more than one step of a FIFO sweep. Synchronizer faults show as a modem bit that rises one cycle too early or too late relative to the three-edge latency.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int STAT_W  = 7;
    localparam int BIT_RT  = 6;
    localparam int BIT_TX  = 5;
    localparam int BIT_RX  = 4;
    localparam int BIT_DSR = 3;
    localparam int BIT_DCD = 2;
    localparam int MODEM_N = 2;

    typedef enum logic [1:0] {
        ADDR_RAW  = 2'd0,
        ADDR_MSK  = 2'd1,
        ADDR_CLR  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        TRIG_1_8 = 3'd0,
        TRIG_1_4 = 3'd1,
        TRIG_1_2 = 3'd2,
        TRIG_3_4 = 3'd3,
        TRIG_7_8 = 3'd4
    } trig_e;

    // Number of FIFO entries that a trigger code stands for.
    function automatic int unsigned trig_entries(input logic [2:0] code,
                                                 input int unsigned depth);
        int unsigned n;
        case (code)
            TRIG_1_8: n = depth / 8;
            TRIG_1_4: n = depth / 4;
            TRIG_1_2: n = depth / 2;
            TRIG_3_4: n = (depth * 3) / 4;
            TRIG_7_8: n = (depth * 7) / 8;
            default:  n = depth / 2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uirq_cross.sv
// Detects a fill level crossing a threshold by comparing this cycle's
// "at or above" flag with the flag registered in the previous cycle.
module uirq_cross #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             went_up,
    output logic             went_down
);

    logic at_or_above;
    logic above_q;

    assign at_or_above = (level >= thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            above_q <= 1'b0;
        end else begin
            above_q <= at_or_above;
        end
    end

    assign went_up   = at_or_above && !above_q;
    assign went_down = !at_or_above && above_q;

endmodule

// File: rtl/uirq_modem_sync.sv
// Per-input synchronizer chain followed by a change detector.
module uirq_modem_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] changed
);

    localparam int CHAIN = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], pin[i]};
            end
        end

        assign changed[i] = chain_q[CHAIN-2] ^ chain_q[CHAIN-1];
    end

endmodule

// File: rtl/uirq_stat_bits.sv
// Sticky status flops: set has priority over clear.
module uirq_stat_bits #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[b] <= 1'b0;
            end else if (set_vec[b]) begin
                stat_q[b] <= 1'b1;
            end else if (clr_vec[b]) begin
                stat_q[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter  int FIFO_DEPTH  = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              eot_mode,
    input  logic [2:0]        tx_trig,
    input  logic [2:0]        rx_trig,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_wr,
    input  logic              rx_rd,
    input  logic              tx_done,
    input  logic              rt_evt,
    input  logic              dsr_in,
    input  logic              dcd_in,
    input  logic [STAT_W-1:0] mask,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq
);

    // Trigger thresholds. The transmit side compares against trigger+1, so
    // "at or above" means "above the trigger". With the FIFO off, both
    // sides use a single entry.
    logic [LVL_W-1:0] tx_trig_n;
    logic [LVL_W-1:0] rx_trig_n;
    logic [LVL_W-1:0] tx_thr;
    logic [LVL_W-1:0] rx_thr;

    assign tx_trig_n = LVL_W'(trig_entries(tx_trig, FIFO_DEPTH));
    assign rx_trig_n = LVL_W'(trig_entries(rx_trig, FIFO_DEPTH));
    assign tx_thr    = fifo_en ? (tx_trig_n + LVL_W'(1)) : LVL_W'(1);
    assign rx_thr    = fifo_en ? rx_trig_n : LVL_W'(1);

    logic tx_up;
    logic tx_down;
    logic rx_up;
    logic rx_down;

    uirq_cross #(.LVL_W(LVL_W)) u_tx_cross (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (tx_level),
        .thresh    (tx_thr),
        .went_up   (tx_up),
        .went_down (tx_down)
    );

    uirq_cross #(.LVL_W(LVL_W)) u_rx_cross (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (rx_level),
        .thresh    (rx_thr),
        .went_up   (rx_up),
        .went_down (rx_down)
    );

    logic [MODEM_N-1:0] modem_chg;

    uirq_modem_sync #(.N(MODEM_N), .STAGES(SYNC_STAGES)) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     ({dcd_in, dsr_in}),
        .changed (modem_chg)
    );

    // Set and clear vectors.
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] auto_clr;
    logic [STAT_W-1:0] wr_clr;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_q;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_RT]  = rt_evt;
        set_vec[BIT_TX]  = eot_mode ? tx_done : tx_down;
        set_vec[BIT_RX]  = rx_up;
        set_vec[BIT_DSR] = modem_chg[0];
        set_vec[BIT_DCD] = modem_chg[1];
    end

    always_comb begin
        auto_clr         = '0;
        auto_clr[BIT_TX] = fifo_en ? tx_up : tx_wr;
        auto_clr[BIT_RX] = fifo_en ? rx_down : rx_rd;
    end

    assign wr_clr  = (bus_wr && (bus_addr == ADDR_CLR)) ? bus_wdata : '0;
    assign clr_vec = wr_clr | auto_clr;

    uirq_stat_bits #(.W(STAT_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    // Views. The timeout bit is hidden in the raw view unless unmasked.
    logic [STAT_W-1:0] raw_view;
    logic [STAT_W-1:0] msk_view;

    always_comb begin
        raw_view         = stat_q;
        raw_view[BIT_RT] = stat_q[BIT_RT] & mask[BIT_RT];
    end

    assign msk_view = raw_view & mask;
    assign irq      = |msk_view;

    always_comb begin
        unique case (bus_addr)
            ADDR_RAW: bus_rdata = raw_view;
            ADDR_MSK: bus_rdata = msk_view;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
    import uirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic [STAT_W-1:0] bus_wdata,
    input logic [STAT_W-1:0] mask,
    input logic [STAT_W-1:0] bus_rdata,
    input logic              irq,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] set_vec,
    input logic [STAT_W-1:0] auto_clr
);

    p_unused_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[1:0] == 2'b00);

    p_clear_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CLR) |=>
            ((stat_q & $past(bus_wdata & ~set_vec)) == '0));

    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_addr == ADDR_CLR) && set_vec == '0 && auto_clr == '0)
            |=> $stable(stat_q));

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    p_rt_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_RAW && !mask[BIT_RT]) |-> !bus_rdata[BIT_RT]);

    p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat_q & mask) != '0));

endmodule

bind uirq_ctrl uirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .mask      (mask),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat_q    (stat_q),
    .set_vec   (set_vec),
    .auto_clr  (auto_clr)
);

// File: tb/tb_uirq_ctrl.sv
module tb_uirq_ctrl;

    localparam int PERIOD = 10;
    localparam int NVEC   = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, eot_mode;
    logic [2:0] tx_trig, rx_trig;
    logic [4:0] tx_level, rx_level;
    logic       tx_wr, rx_rd, tx_done, rt_evt, dsr_in, dcd_in;
    logic [6:0] mask;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [6:0] bus_wdata;
    logic [6:0] bus_rdata;
    logic       irq;

    int vectors     = 0;
    int miscompares = 0;
    bit finished    = 0;

    always #(PERIOD / 2) clk = ~clk;

    uirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_level(tx_level),
        .rx_level(rx_level), .tx_wr(tx_wr), .rx_rd(rx_rd), .tx_done(tx_done),
        .rt_evt(rt_evt), .dsr_in(dsr_in), .dcd_in(dcd_in), .mask(mask),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {tx_level, rx_level, tx_wr, rx_rd, tx_done, rt_evt, clear data, expected raw}
    // Config: FIFO on, level mode, tx trigger 8, rx trigger 4, mask 7C.
    localparam logic [27:0] VEC [NVEC] = '{
        {5'd12, 5'd0, 4'b0000, 7'h00, 7'h00},
        {5'd8,  5'd0, 4'b0000, 7'h00, 7'h20},
        {5'd9,  5'd0, 4'b0000, 7'h00, 7'h00},
        {5'd5,  5'd0, 4'b0000, 7'h00, 7'h20},
        {5'd5,  5'd4, 4'b0000, 7'h00, 7'h30},
        {5'd5,  5'd6, 4'b0000, 7'h00, 7'h30},
        {5'd5,  5'd3, 4'b0000, 7'h00, 7'h20},
        {5'd5,  5'd3, 4'b0000, 7'h20, 7'h00},
        {5'd5,  5'd3, 4'b0001, 7'h00, 7'h40},
        {5'd5,  5'd3, 4'b0000, 7'h10, 7'h40},
        {5'd5,  5'd5, 4'b0000, 7'h40, 7'h10},
        {5'd5,  5'd5, 4'b0000, 7'h10, 7'h00},
        {5'd5,  5'd2, 4'b0000, 7'h00, 7'h00},
        {5'd10, 5'd2, 4'b0000, 7'h00, 7'h00},
        {5'd4,  5'd2, 4'b0000, 7'h20, 7'h20},
        {5'd4,  5'd2, 4'b0000, 7'h20, 7'h00}
    };

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        tx_wr = 0; rx_rd = 0; tx_done = 0; rt_evt = 0;
        bus_wr = 0; bus_wdata = '0; bus_addr = 2'd0;
        #1;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [6:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = 2'd0;
    endtask

    task automatic clear_wr(input logic [6:0] d);
        bus_addr = 2'd2; bus_wr = 1; bus_wdata = d;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 0; fifo_en = 1; eot_mode = 0; tx_trig = 3'd2; rx_trig = 3'd1;
        tx_level = 0; rx_level = 0; tx_wr = 0; rx_rd = 0; tx_done = 0;
        rt_evt = 0; dsr_in = 0; dcd_in = 0; mask = 7'h7C;
        bus_addr = 0; bus_wr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        read_chk("R1 raw after reset", 2'd0, 7'h00);
        read_chk("R1 masked after reset", 2'd1, 7'h00);
        read_chk("R1 unused address", 2'd3, 7'h00);
        check("R1 irq after reset", {6'd0, irq}, 7'h00);

        // Table walk: R3 R5 R6 R7 R8 R12 R2
        for (int i = 0; i < NVEC; i++) begin
            tx_level = VEC[i][27:23];
            rx_level = VEC[i][22:18];
            tx_wr    = VEC[i][17];
            rx_rd    = VEC[i][16];
            tx_done  = VEC[i][15];
            rt_evt   = VEC[i][14];
            if (VEC[i][13:7] != 0) begin
                bus_addr = 2'd2; bus_wr = 1; bus_wdata = VEC[i][13:7];
            end
            tick();
            read_chk($sformatf("vector %0d (R3 R5 R6 R7 R12)", i), 2'd0, VEC[i][6:0]);
        end

        // R10: every trigger code on the receive side
        for (int c = 0; c < 8; c++) begin
            int thr;
            do_reset();
            rx_trig = 3'(c);
            case (c)
                0: thr = 2;
                1: thr = 4;
                3: thr = 12;
                4: thr = 14;
                default: thr = 8;
            endcase
            rx_level = 5'(thr - 1); tick();
            read_chk($sformatf("R10 code %0d below trigger", c), 2'd0, 7'h00);
            rx_level = 5'(thr); tick();
            read_chk($sformatf("R10 code %0d at trigger", c), 2'd0, 7'h10);
            rx_level = 0; tick();
            read_chk($sformatf("R10 code %0d drained", c), 2'd0, 7'h00);
        end

        // R4: end-of-transmission mode
        do_reset();
        eot_mode = 1;
        tx_level = 5'd12; tick();
        tx_level = 5'd3;  tick();
        read_chk("R4 level fall ignored", 2'd0, 7'h00);
        tx_done = 1; tick();
        read_chk("R4 tx_done sets", 2'd0, 7'h20);
        clear_wr(7'h20);
        read_chk("R4 cleared by write", 2'd0, 7'h00);

        // FIFO disabled: R3 R5 R6 R7
        do_reset();
        fifo_en = 0;
        tx_level = 5'd1; tick();
        read_chk("R3 holding reg filled", 2'd0, 7'h00);
        tx_level = 5'd0; tick();
        read_chk("R3 holding reg emptied sets", 2'd0, 7'h20);
        tx_wr = 1; tx_level = 5'd1; tick();
        read_chk("R5 single write clears", 2'd0, 7'h00);
        rx_level = 5'd1; tick();
        read_chk("R6 single byte sets", 2'd0, 7'h10);
        rx_rd = 1; rx_level = 5'd0; tick();
        read_chk("R7 single read clears", 2'd0, 7'h00);

        // R9: modem inputs, three-edge latency
        do_reset();
        dsr_in = 1;
        tick(); read_chk("R9 dsr edge 1", 2'd0, 7'h00);
        tick(); read_chk("R9 dsr edge 2", 2'd0, 7'h00);
        tick(); read_chk("R9 dsr edge 3", 2'd0, 7'h08);
        dcd_in = 1;
        repeat (3) tick();
        read_chk("R9 dcd sets", 2'd0, 7'h0C);
        dsr_in = 0;
        repeat (4) tick();
        read_chk("R9 dsr fall keeps set", 2'd0, 7'h0C);
        clear_wr(7'h08);
        read_chk("R2 clear one modem bit", 2'd0, 7'h04);
        clear_wr(7'h00);
        read_chk("R2 zero write no effect", 2'd0, 7'h04);

        // R11: masked view and irq
        mask = 7'h08; #1;
        read_chk("R11 masked view other bit", 2'd1, 7'h00);
        check("R11 irq low", {6'd0, irq}, 7'h00);
        mask = 7'h04; #1;
        read_chk("R11 masked view hit", 2'd1, 7'h04);
        check("R11 irq high", {6'd0, irq}, 7'h01);
        mask = 7'h00; #1;
        check("R11 irq all masked", {6'd0, irq}, 7'h00);

        // R8: timeout visibility
        do_reset();
        mask = 7'h00;
        rt_evt = 1; tick();
        read_chk("R8 hidden when masked", 2'd0, 7'h00);
        mask = 7'h40; #1;
        read_chk("R8 raw visible", 2'd0, 7'h40);
        read_chk("R8 masked visible", 2'd1, 7'h40);
        check("R8 irq", {6'd0, irq}, 7'h01);
        mask = 7'h00; tick();
        read_chk("R8 hidden again", 2'd0, 7'h00);
        mask = 7'h40; #1;
        read_chk("R8 retained", 2'd0, 7'h40);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule